// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Bank

This block holds the digital state that sits between a host processor bus and an eight-channel, 14-bit voltage-output converter. The host writes one parallel word at a time into a per-channel staging register using an active-low select, an active-low write strobe and a 3-bit channel address. A separate active-low load strobe moves every staged word into the code register that drives the analog side, so all channels can change together. While the load strobe is held low, the bank is transparent and each write reaches its output directly.

An active-low clear overrides every presented code with a fixed clear code and raises a flag for the analog side, which uses the flag to switch the outputs to their ground-sense level. Clear never changes stored data. Once clear is released, each channel again presents its code register. All host strobes are asynchronous to the system clock and are resynchronised before use. Codes are straight binary and pass through unchanged, bit 13 most significant.

Top module: `dacrb_top`

## Requirements
- R1: After reset every staging and code register holds zero, every presented code is zero, and the clear flag follows only the clear input.
- R2: A rising edge of the write strobe while select is low stores the 14-bit data word unchanged (bit 13 MSB) into the staging register of the addressed channel; address k selects channel k, presented on `dac_code[14*k +: 14]`, so 0 is the first channel and 7 the last.
- R3: A write strobe edge while select is high changes no register.
- R4: While the load strobe is high, a write changes only the staging register; the presented code stays as it was.
- R5: While the load strobe is low, every staging register is copied into its code register, all channels in the same cycle.
- R6: With the load strobe held low, a write updates the addressed channel's presented code; a write and an active load in the same cycle give the newly written word.
- R7: While clear is low, every presented code equals the clear code (zero) and the clear flag is high.
- R8: Clear leaves stored data unchanged, and writes and loads during clear still take effect; after clear returns high every channel presents its code register.
- R9: A write strobe held low stores nothing; exactly one store happens per rising edge, to at most one channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel_n | input | 1 | Active-low select for the host bus |
| bus_wr_n | input | 1 | Active-low write strobe; storing happens on its rising edge |
| bus_addr | input | 3 | Channel address |
| bus_data | input | 14 | Parallel data word, bit 13 MSB |
| load_n | input | 1 | Active-low level-sensitive global load |
| clear_n | input | 1 | Active-low clear of the presented codes |
| dac_code | output | 112 | Eight presented 14-bit codes, channel k at bits 14*k+13..14*k |
| clear_active | output | 1 | High while clear is in effect |

## Verification
Every cycle, the assertions check that at most one channel is written per cycle and that a write edge can't fire on consecutive cycles. They also check that a code register holds while load is inactive, that it takes the staged word or the fresh write word while load is active, and that the presented codes equal the clear code while clear is active. Only the bench scenarios can show the end-to-end behaviour across the resynchronisers. That covers address-to-channel mapping and bit order, writes ignored while select is high, the double-buffer separation, and stored data surviving a clear and reappearing on release. It also covers a long-held write strobe, which must store nothing until it rises.

// File: rtl/dacrb_pkg.sv
package dacrb_pkg;
  parameter int CH_NUM = 8;
  parameter int CODE_W = 14;
  parameter int ADDR_W = $clog2(CH_NUM);
endpackage

// File: rtl/dacrb_sync.sv
module dacrb_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign q_out = stage2_q;
endmodule

// File: rtl/dacrb_wr_decode.sv
module dacrb_wr_decode #(
  parameter int CH_NUM = dacrb_pkg::CH_NUM,
  parameter int CODE_W = dacrb_pkg::CODE_W,
  parameter int ADDR_W = dacrb_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n_s,
  input  logic              sel_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [CODE_W-1:0] data_s,
  output logic [CH_NUM-1:0] wr_en,
  output logic [CODE_W-1:0] wr_data
);
  logic              wr_p_q, wr_p_d;
  logic              sel_p_q, sel_p_d;
  logic [ADDR_W-1:0] addr_p_q, addr_p_d;
  logic [CODE_W-1:0] data_p_q, data_p_d;
  logic              wr_edge;

  always_comb begin
    wr_p_d   = wr_n_s;
    sel_p_d  = sel_n_s;
    addr_p_d = addr_s;
    data_p_d = data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p_q   <= 1'b1;
      sel_p_q  <= 1'b1;
      addr_p_q <= '0;
      data_p_q <= '0;
    end else begin
      wr_p_q   <= wr_p_d;
      sel_p_q  <= sel_p_d;
      addr_p_q <= addr_p_d;
      data_p_q <= data_p_d;
    end
  end

  // Rising edge of the strobe, qualified by select as it was while the strobe was low.
  assign wr_edge = wr_n_s && !wr_p_q && !sel_p_q;

  for (genvar k = 0; k < CH_NUM; k++) begin : g_dec
    assign wr_en[k] = wr_edge && (addr_p_q == ADDR_W'(k));
  end

  assign wr_data = data_p_q;

  // R9: one channel at most per cycle
  p_single_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R9: an edge cannot repeat on the next cycle
  p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |=> !(|wr_en));
endmodule

// File: rtl/dacrb_channel.sv
module dacrb_channel #(
  parameter int CODE_W = dacrb_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              load_act,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] stage_q, stage_d;
  logic [CODE_W-1:0] dac_q, dac_d;
  logic              stage_en, dac_en;

  always_comb begin
    stage_en = wr_hit;
    dac_en   = load_act;
    stage_d  = wr_data;
    dac_d    = wr_hit ? wr_data : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      dac_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (dac_en)   dac_q   <= dac_d;
    end
  end

  assign code_q = dac_q;

  // R4: code register holds while load is inactive
  p_hold_without_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> $stable(code_q));

  // R5: active load with no write copies the staged word
  p_load_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && !wr_hit) |=> (code_q == $past(stage_q)));

  // R6: write coinciding with active load wins
  p_write_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && wr_hit) |=> (code_q == $past(wr_data)));
endmodule

// File: rtl/dacrb_top.sv
module dacrb_top #(
  parameter int              CH_NUM     = dacrb_pkg::CH_NUM,
  parameter int              CODE_W     = dacrb_pkg::CODE_W,
  parameter int              ADDR_W     = $clog2(CH_NUM),
  parameter logic [CODE_W-1:0] CLEAR_CODE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel_n,
  input  logic                     bus_wr_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [CODE_W-1:0]        bus_data,
  input  logic                     load_n,
  input  logic                     clear_n,
  output logic [CH_NUM*CODE_W-1:0] dac_code,
  output logic                     clear_active
);
  localparam int STROBE_W = 4;
  localparam int BUS_W    = ADDR_W + CODE_W;

  logic [STROBE_W-1:0] strobe_s;
  logic [BUS_W-1:0]    bus_s;
  logic                wr_n_s, sel_n_s, load_n_s, clear_n_s;
  logic [ADDR_W-1:0]   addr_s;
  logic [CODE_W-1:0]   data_s;
  logic [CH_NUM-1:0]   wr_en;
  logic [CODE_W-1:0]   wr_data;
  logic                load_act, clear_act;

  dacrb_sync #(.W(STROBE_W), .RST_VAL({STROBE_W{1'b1}})) u_sync_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({bus_wr_n, bus_sel_n, load_n, clear_n}),
    .q_out (strobe_s)
  );

  dacrb_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({bus_addr, bus_data}),
    .q_out (bus_s)
  );

  assign {wr_n_s, sel_n_s, load_n_s, clear_n_s} = strobe_s;
  assign {addr_s, data_s} = bus_s;
  assign load_act  = !load_n_s;
  assign clear_act = !clear_n_s;

  dacrb_wr_decode #(.CH_NUM(CH_NUM), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n_s  (wr_n_s),
    .sel_n_s (sel_n_s),
    .addr_s  (addr_s),
    .data_s  (data_s),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  for (genvar k = 0; k < CH_NUM; k++) begin : g_ch
    logic [CODE_W-1:0] ch_code;

    dacrb_channel #(.CODE_W(CODE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_en[k]),
      .wr_data  (wr_data),
      .load_act (load_act),
      .code_q   (ch_code)
    );

    assign dac_code[k*CODE_W +: CODE_W] = clear_act ? CLEAR_CODE : ch_code;
  end

  assign clear_active = clear_act;

  // R7: flag and forced codes agree on every cycle
  p_clear_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_active |-> (dac_code == {CH_NUM{CLEAR_CODE}}));
endmodule

// File: tb/dacrb_top_tb_top.sv
module dacrb_top_tb_top;
  localparam int CH = 8;
  localparam int W  = 14;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel_n, bus_wr_n, load_n, clear_n;
  logic [2:0]      bus_addr;
  logic [W-1:0]    bus_data;
  logic [CH*W-1:0] dac_code;
  logic            clear_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [W-1:0] stage_m [CH];
  logic [W-1:0] dac_m   [CH];
  bit           clr_m;
  bit           load_hold;

  always #5 clk = ~clk;

  dacrb_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_data(bus_data), .load_n(load_n), .clear_n(clear_n),
    .dac_code(dac_code), .clear_active(clear_active)
  );

  function automatic logic [W-1:0] exp_code(int k);
    return clr_m ? '0 : dac_m[k];
  endfunction

  task automatic check_all(string req);
    for (int k = 0; k < CH; k++) begin
      n_tests++;
      if (dac_code[k*W +: W] !== exp_code(k)) begin
        n_fail++;
        $display("FAIL %s ch%0d actual=%h expected=%h", req, k, dac_code[k*W +: W], exp_code(k));
      end
    end
    n_tests++;
    if (clear_active !== clr_m) begin
      n_fail++;
      $display("FAIL %s clear_active actual=%b expected=%b", req, clear_active, clr_m);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [W-1:0] d, logic sel_n);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_sel_n = sel_n;
    settle(2);
    bus_wr_n = 1'b0;
    settle(3);
    bus_wr_n = 1'b1;
    settle(5);
    bus_sel_n = 1'b1;
    if (!sel_n) begin
      stage_m[a] = d;
      if (load_hold) dac_m[a] = d;
    end
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_n = 1'b0;
    settle(3);
    load_n = 1'b1;
    settle(4);
    for (int k = 0; k < CH; k++) dac_m[k] = stage_m[k];
  endtask

  task automatic set_clear(bit on);
    @(negedge clk);
    clear_n = !on;
    settle(4);
    clr_m = on;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; bus_sel_n = 1'b1; bus_wr_n = 1'b1; load_n = 1'b1; clear_n = 1'b1;
    bus_addr = '0; bus_data = '0; clr_m = 0; load_hold = 0;
    for (int k = 0; k < CH; k++) begin stage_m[k] = '0; dac_m[k] = '0; end
    settle(3);
    rst_n = 1'b1;
    settle(3);
    check_all("R1");

    // R2/R4: stage distinct values, outputs must not move before load
    for (int k = 0; k < CH; k++) bus_write(3'(k), W'(14'h2000 | (k * 14'h111)), 1'b0);
    check_all("R4");
    // R5: one load moves all channels
    pulse_load();
    check_all("R5");
    // R2: bit order and extremes on first and last channel
    bus_write(3'd0, 14'h3FFF, 1'b0);
    bus_write(3'd7, 14'h0001, 1'b0);
    pulse_load();
    check_all("R2");

    // R3: write with select high ignored, seen after a load
    bus_write(3'd3, 14'h1555, 1'b1);
    pulse_load();
    check_all("R3");

    // R9: held strobe stores nothing until it rises
    @(negedge clk);
    bus_addr = 3'd5; bus_data = 14'h0ABC; bus_sel_n = 1'b0;
    settle(2);
    bus_wr_n = 1'b0;
    settle(12);
    pulse_load();
    check_all("R9");
    bus_wr_n = 1'b1;
    settle(5);
    bus_sel_n = 1'b1;
    stage_m[5] = 14'h0ABC;
    pulse_load();
    check_all("R9");

    // R6: load held low, writes go straight through
    @(negedge clk);
    load_n = 1'b0;
    settle(4);
    load_hold = 1;
    bus_write(3'd2, 14'h2D2D, 1'b0);
    check_all("R6");
    bus_write(3'd6, 14'h1234, 1'b0);
    check_all("R6");
    load_n = 1'b1;
    settle(4);
    load_hold = 0;

    // R7/R8: clear forces, storage survives, activity during clear lands
    set_clear(1);
    check_all("R7");
    bus_write(3'd1, 14'h3A5A, 1'b0);
    check_all("R7");
    pulse_load();
    check_all("R8");
    set_clear(0);
    check_all("R8");

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 5) bus_write(3'($urandom % 8), W'($urandom), (($urandom % 6) == 0));
      else if (op < 7) pulse_load();
      else set_clear(!clr_m);
      check_all("R2 R5 R7 random");
    end
    if (clr_m) begin set_clear(0); check_all("R8"); end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule